// File: doc/BRIEF.md
# Scaled Fixed-Point Timestamp Counter

This block keeps a system-wide timestamp that other timer blocks read from a 64-bit output bus and that software reads through two register windows of 4 KB each. The count lives in an 88-bit accumulator. The upper 64 bits are the visible count and the lower 24 bits are a binary fraction. On every clock cycle while the counter is running, the accumulator gains either a fixed increment of exactly one count or a programmable 32-bit scale value in 8.24 fixed-point form. A scale below 1.0 lets a fast clock produce a slower timestamp, and a scale above 1.0 does the reverse, with the remainder carried in the fraction bits from tick to tick.

The writable control window holds the configuration word, the scale value, a writable count and identification words. Software can overwrite either 32-bit half of the running count without disturbing the other half. The status window is read-only. It mirrors the count and carries its own identification bytes. Each window has its own select line on a simple 32-bit single-cycle register bus. Read data is combinational from the current state.

Top module: `tstamp_counter`

## Requirements
- R1: After reset the configuration word reads 0, the scale value reads 0x01000000 and the count is 0.
- R2: While the run bit (configuration bit 0) is 0, the count does not change unless software writes it.
- R3: With run = 1 and scale-enable (configuration bit 2) = 0, the count rises by exactly 1 on every clock cycle, carrying from the low half into the high half. The fraction bits are unchanged.
- R4: With run = 1 and scale-enable = 1, each cycle adds the 32-bit scale value to the 88-bit accumulator (24 fraction bits). The visible count is the accumulator's upper 64 bits, and the fraction carries over between runs.
- R5: The configuration word at control offset 0x000 stores bits 4:0: run at 0, debug-halt at 1, scale-enable at 2, interrupt-mask at 3 and error-disable at 4. Bits 31:5 read as zero whatever is written.
- R6: A control write to 0x008 replaces count bits 31:0, and a write to 0x00C replaces count bits 63:32. The other half keeps its live value, the 24 fraction bits are cleared, and the write takes priority over that cycle's increment.
- R7: In the control window, 0x004 always reads 0. The scale value is readable and writable at both 0x010 and 0x0D0. Offset 0x0D4 reads 0 and ignores writes. Offset 0x01C reads 0x00020001.
- R8: The status window returns count bits 31:0 at 0x000 and bits 63:32 at 0x004. Writes to the status window change nothing.
- R9: Both windows return one identification byte per word at 0xFD0 through 0xFFC, in this order: 0x04, 0x00, 0x00, 0x00, P0, 0xB0, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. P0 is 0xBA in the control window and 0xBB in the status window.
- R10: Reads of unmapped offsets return 0. Writes to unmapped or read-only control offsets change no state.
- R11: The count_out port always equals the count that the register reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one counter tick |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_sel | input | 1 | Selects the control window |
| sts_sel | input | 1 | Selects the status window |
| bus_en | input | 1 | Access strobe; a write takes effect on the edge where it is high |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the selected window, 0 if none is selected |
| count_out | output | 64 | Visible 64-bit timestamp |

## Verification
The assertions check the following on every cycle:
- The hold rule while stopped.
- The exact unit step.
- The 88-bit scaled addition against the accumulator.
- The effect of a low-half count write.
- The configuration read-back mask, the constant feature word and the status mirror of the count.

Only the bench's scenarios show the rest:
- The fraction carrying across separate runs.
- Carries between the two count halves.
- The scale alias and the ignored registers.
- The full identification byte order in both windows.
- The return to reset values after a reset in mid-operation.

// File: rtl/ts_pkg.sv
// Package: shared offsets and identification data for the timestamp counter.
// Assumes 12-bit byte offsets within each 4 KB window and word-aligned access.
package ts_pkg;
    localparam logic [11:0] CTL_CFG       = 12'h000;
    localparam logic [11:0] CTL_FLAGS     = 12'h004;
    localparam logic [11:0] CTL_CNT_LO    = 12'h008;
    localparam logic [11:0] CTL_CNT_HI    = 12'h00C;
    localparam logic [11:0] CTL_SCALE     = 12'h010;
    localparam logic [11:0] CTL_FEATURES  = 12'h01C;
    localparam logic [11:0] CTL_SCALE_ALT = 12'h0D0;
    localparam logic [11:0] CTL_SCALE2    = 12'h0D4;
    localparam logic [11:0] STS_CNT_LO    = 12'h000;
    localparam logic [11:0] STS_CNT_HI    = 12'h004;
    localparam logic [11:0] ID_FIRST      = 12'hFD0;
    localparam logic [11:0] ID_LAST       = 12'hFFC;
    localparam int          CFG_W         = 5;
    localparam logic [31:0] SCALE_RESET   = 32'h0100_0000;
    localparam logic [31:0] FEATURE_WORD  = 32'h0002_0001;

    // Identification byte for slot idx (0..11); status window differs in slot 4.
    function automatic logic [7:0] id_byte(input logic is_status, input logic [3:0] idx);
        case (idx)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = is_status ? 8'hBB : 8'hBA;
            4'd5:    id_byte = 8'hB0;
            4'd6:    id_byte = 8'h0B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/ts_ctl_regs.sv
// Control-window write decode: holds the configuration bits and the scale
// value, and produces one-cycle strobes for writes to the two count halves.
// Assumes a write is one cycle with sel, en and wr all high.
module ts_ctl_regs
    import ts_pkg::*;
#(
    parameter int SCALE_W = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [11:0]        addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [CFG_W-1:0]   cfg,
    output logic [SCALE_W-1:0] scale,
    output logic               cnt_wr_lo,
    output logic               cnt_wr_hi
);
    // Configuration and scale registers; all other offsets ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg   <= '0;
            scale <= SCALE_W'(SCALE_RESET);
        end else if (wr_stb) begin
            case (addr)
                CTL_CFG:                  cfg   <= wdata[CFG_W-1:0];
                CTL_SCALE, CTL_SCALE_ALT: scale <= wdata[SCALE_W-1:0];
                default: ;
            endcase
        end
    end

    // Count-half write strobes, consumed by the accumulator.
    always_comb begin
        cnt_wr_lo = wr_stb && (addr == CTL_CNT_LO);
        cnt_wr_hi = wr_stb && (addr == CTL_CNT_HI);
    end
endmodule

// File: rtl/ts_accum.sv
// Fixed-point accumulator: CNT_W integer bits over FRAC_W fraction bits.
// Adds one whole count or the scale value per running cycle. A count-half
// write replaces that half, clears the fraction and wins over the increment.
module ts_accum #(
    parameter int CNT_W   = 64,
    parameter int FRAC_W  = 24,
    parameter int SCALE_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     scale_on,
    input  logic [SCALE_W-1:0]       scale,
    input  logic                     wr_lo,
    input  logic                     wr_hi,
    input  logic [CNT_W/2-1:0]       wdata,
    output logic [CNT_W+FRAC_W-1:0]  acc
);
    localparam int ACC_W = CNT_W + FRAC_W;
    localparam int HALF  = CNT_W / 2;
    localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

    logic [ACC_W-1:0] step;

    // Per-cycle increment: scaled value or one whole count.
    always_comb step = scale_on ? ACC_W'(scale) : UNIT;

    // Accumulator update with count writes taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (wr_lo)
            acc <= {acc[ACC_W-1 -: HALF], wdata, {FRAC_W{1'b0}}};
        else if (wr_hi)
            acc <= {wdata, acc[FRAC_W +: HALF], {FRAC_W{1'b0}}};
        else if (run)
            acc <= acc + step;
    end
endmodule

// File: rtl/ts_rd_mux.sv
// Read-data multiplexer for both windows. The control window wins if both
// selects are high; with no select the output is zero.
module ts_rd_mux
    import ts_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int SCALE_W = 32,
    parameter int DATA_W  = 32
) (
    input  logic               ctl_sel,
    input  logic               sts_sel,
    input  logic [11:0]        addr,
    input  logic [CFG_W-1:0]   cfg,
    input  logic [SCALE_W-1:0] scale,
    input  logic [CNT_W-1:0]   count,
    output logic [DATA_W-1:0]  rdata
);
    localparam int HALF = CNT_W / 2;

    logic       in_id;
    logic [3:0] id_idx;
    logic [11:0] id_off;

    // Identification slot decode shared by both windows.
    always_comb begin
        in_id  = (addr >= ID_FIRST) && (addr <= ID_LAST) && (addr[1:0] == 2'b00);
        id_off = addr - ID_FIRST;
        id_idx = id_off[5:2];
    end

    // Window select and register decode.
    always_comb begin
        rdata = '0;
        if (ctl_sel) begin
            case (addr)
                CTL_CFG:                  rdata = DATA_W'(cfg);
                CTL_CNT_LO:               rdata = DATA_W'(count[HALF-1:0]);
                CTL_CNT_HI:               rdata = DATA_W'(count[CNT_W-1:HALF]);
                CTL_SCALE, CTL_SCALE_ALT: rdata = DATA_W'(scale);
                CTL_FEATURES:             rdata = DATA_W'(FEATURE_WORD);
                default:                  rdata = in_id ? DATA_W'(id_byte(1'b0, id_idx)) : '0;
            endcase
        end else if (sts_sel) begin
            case (addr)
                STS_CNT_LO: rdata = DATA_W'(count[HALF-1:0]);
                STS_CNT_HI: rdata = DATA_W'(count[CNT_W-1:HALF]);
                default:    rdata = in_id ? DATA_W'(id_byte(1'b1, id_idx)) : '0;
            endcase
        end
    end
endmodule

// File: rtl/tstamp_counter.sv
// Top: scaled fixed-point timestamp counter with a control window and a
// read-only status window on a single-cycle 32-bit register bus.
// Assumes one tick per clock edge and 32-bit word accesses only.
module tstamp_counter
    import ts_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int FRAC_W  = 24,
    parameter int SCALE_W = 32,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_sel,
    input  logic              sts_sel,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  count_out
);
    localparam int ACC_W    = CNT_W + FRAC_W;
    localparam int RUN_BIT  = 0;
    localparam int SCEN_BIT = 2;

    logic                 ctl_wr;
    logic [CFG_W-1:0]     cfg;
    logic [SCALE_W-1:0]   scale_q;
    logic                 wr_lo;
    logic                 wr_hi;
    logic                 run;
    logic                 scale_on;
    logic [ACC_W-1:0]     acc;

    // Control-window write strobe and configuration bit extraction.
    always_comb begin
        ctl_wr    = ctl_sel && bus_en && bus_wr;
        run       = cfg[RUN_BIT];
        scale_on  = cfg[SCEN_BIT];
        count_out = acc[ACC_W-1:FRAC_W];
    end

    ts_ctl_regs #(.SCALE_W(SCALE_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(ctl_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cfg(cfg), .scale(scale_q),
        .cnt_wr_lo(wr_lo), .cnt_wr_hi(wr_hi)
    );

    ts_accum #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .run(run), .scale_on(scale_on),
        .scale(scale_q), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(bus_wdata[CNT_W/2-1:0]), .acc(acc)
    );

    ts_rd_mux #(.CNT_W(CNT_W), .SCALE_W(SCALE_W), .DATA_W(DATA_W)) u_rd (
        .ctl_sel(ctl_sel), .sts_sel(sts_sel), .addr(bus_addr), .cfg(cfg),
        .scale(scale_q), .count(count_out), .rdata(bus_rdata)
    );
endmodule

// File: rtl/ts_checker.sv
// Checker for tstamp_counter: cycle-by-cycle properties of the counting,
// the count writes and the fixed read values. Bound into the top below.
module ts_checker #(
    parameter int CNT_W   = 64,
    parameter int FRAC_W  = 24,
    parameter int SCALE_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ctl_sel,
    input logic                    sts_sel,
    input logic                    bus_en,
    input logic                    bus_wr,
    input logic [11:0]             bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [31:0]             bus_rdata,
    input logic [CNT_W-1:0]        count_out,
    input logic                    run,
    input logic                    scale_on,
    input logic [SCALE_W-1:0]      scale_q,
    input logic [CNT_W+FRAC_W-1:0] acc
);
    localparam int ACC_W = CNT_W + FRAC_W;
    logic cwr, cnt_wr, lo_wr;

    // Count-write decode seen at the ports.
    always_comb begin
        cwr    = ctl_sel && bus_en && bus_wr;
        lo_wr  = cwr && (bus_addr == 12'h008);
        cnt_wr = lo_wr || (cwr && (bus_addr == 12'h00C));
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count_out));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !scale_on && !cnt_wr) |=> (count_out == $past(count_out) + 1'b1));

    p_scale_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && scale_on && !cnt_wr) |=> (acc == $past(acc) + ACC_W'($past(scale_q))));

    p_cfg_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sel && bus_addr == 12'h000) |-> (bus_rdata[31:5] == 27'd0));

    p_lo_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (count_out == {$past(count_out[CNT_W-1:32]), $past(bus_wdata)})
                  && (acc[FRAC_W-1:0] == '0));

    p_features_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sel && bus_addr == 12'h01C) |-> (bus_rdata == 32'h0002_0001));

    p_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_sel && !ctl_sel && bus_addr == 12'h000) |-> (bus_rdata == count_out[31:0]));
endmodule

bind tstamp_counter ts_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .sts_sel(sts_sel),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_out(count_out),
    .run(run), .scale_on(scale_on), .scale_q(scale_q), .acc(acc)
);

// File: tb/sim_tstamp_counter.sv
// Bench for tstamp_counter: a vector table of register accesses walked by one
// loop, then directed runs for counting, scaling, count writes and reset.
module sim_tstamp_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_sel = 1'b0, sts_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] count_out;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    tstamp_counter u0 (
        .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .sts_sel(sts_sel),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_out(count_out)
    );

    // Entry: {req[3:0], op[3:0], addr[11:0], data[31:0], expect[31:0]}
    // op 0 = control read, 1 = control write, 2 = status read, 3 = status write
    localparam int NV = 40;
    localparam logic [83:0] VEC [NV] = '{
        {4'd5,  4'h1, 12'h000, 32'h0000_001E, 32'h0},          // R5 store bits 4:1
        {4'd5,  4'h0, 12'h000, 32'h0,         32'h0000_001E},
        {4'd5,  4'h1, 12'h000, 32'hFFFF_FFE0, 32'h0},          // R5 upper bits only
        {4'd5,  4'h0, 12'h000, 32'h0,         32'h0},
        {4'd5,  4'h1, 12'h000, 32'h0000_003E, 32'h0},
        {4'd5,  4'h0, 12'h000, 32'h0,         32'h0000_001E},
        {4'd2,  4'h1, 12'h000, 32'h0,         32'h0},          // R2 stopped
        {4'd6,  4'h1, 12'h008, 32'h1122_3344, 32'h0},          // R6 low half
        {4'd6,  4'h0, 12'h008, 32'h0,         32'h1122_3344},
        {4'd6,  4'h0, 12'h00C, 32'h0,         32'h0},
        {4'd6,  4'h1, 12'h00C, 32'hAABB_CCDD, 32'h0},          // R6 high half
        {4'd6,  4'h0, 12'h008, 32'h0,         32'h1122_3344},
        {4'd6,  4'h0, 12'h00C, 32'h0,         32'hAABB_CCDD},
        {4'd8,  4'h2, 12'h000, 32'h0,         32'h1122_3344},  // R8 mirror
        {4'd8,  4'h2, 12'h004, 32'h0,         32'hAABB_CCDD},
        {4'd8,  4'h3, 12'h000, 32'h0000_DEAD, 32'h0},          // R8 write ignored
        {4'd8,  4'h3, 12'h004, 32'h0000_BEEF, 32'h0},
        {4'd8,  4'h2, 12'h000, 32'h0,         32'h1122_3344},
        {4'd8,  4'h2, 12'h004, 32'h0,         32'hAABB_CCDD},
        {4'd10, 4'h1, 12'h01C, 32'hFFFF_FFFF, 32'h0},          // R10 RO write
        {4'd7,  4'h0, 12'h01C, 32'h0,         32'h0002_0001},  // R7 features
        {4'd10, 4'h1, 12'h004, 32'hFFFF_FFFF, 32'h0},
        {4'd7,  4'h0, 12'h004, 32'h0,         32'h0},
        {4'd7,  4'h1, 12'h0D0, 32'h0040_0000, 32'h0},          // R7 alias
        {4'd7,  4'h0, 12'h010, 32'h0,         32'h0040_0000},
        {4'd7,  4'h1, 12'h0D4, 32'h0000_1234, 32'h0},
        {4'd7,  4'h0, 12'h0D4, 32'h0,         32'h0},
        {4'd7,  4'h0, 12'h0D0, 32'h0,         32'h0040_0000},
        {4'd7,  4'h1, 12'h010, 32'h0100_0000, 32'h0},
        {4'd7,  4'h0, 12'h0D0, 32'h0,         32'h0100_0000},
        {4'd10, 4'h0, 12'h020, 32'h0,         32'h0},          // R10 unmapped
        {4'd10, 4'h1, 12'h024, 32'h0000_FFFF, 32'h0},
        {4'd10, 4'h0, 12'h010, 32'h0,         32'h0100_0000},
        {4'd9,  4'h0, 12'hFD0, 32'h0,         32'h04},         // R9 identification
        {4'd9,  4'h0, 12'hFE0, 32'h0,         32'hBA},
        {4'd9,  4'h0, 12'hFE8, 32'h0,         32'h0B},
        {4'd9,  4'h0, 12'hFFC, 32'h0,         32'hB1},
        {4'd9,  4'h2, 12'hFE0, 32'h0,         32'hBB},
        {4'd9,  4'h2, 12'hFF4, 32'h0,         32'hF0},
        {4'd10, 4'h2, 12'h008, 32'h0,         32'h0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write; called at a negedge, returns at the next negedge.
    task automatic wr(input logic sts, input logic [11:0] a, input logic [31:0] d);
        ctl_sel = !sts; sts_sel = sts; bus_en = 1'b1; bus_wr = 1'b1;
        bus_addr = a; bus_wdata = d;
        @(negedge clk);
        ctl_sel = 1'b0; sts_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sts, input logic [11:0] a, output logic [31:0] d);
        ctl_sel = !sts; sts_sel = sts; bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        ctl_sel = 1'b0; sts_sel = 1'b0; bus_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Enable with the given configuration, idle k cycles, stop: k+1 ticks.
    task automatic run_for(input logic [31:0] cfg, input int k);
        wr(1'b0, 12'h000, cfg);
        idle(k);
        wr(1'b0, 12'h000, 32'h0);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 count", count_out, 64'h0);
        rd(1'b0, 12'h000, r); check("R1 cfg", 64'(r), 64'h0);
        rd(1'b0, 12'h010, r); check("R1 scale", 64'(r), 64'h0100_0000);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq, op; logic [11:0] a; logic [31:0] d, e;
            {rq, op, a, d, e} = VEC[i];
            if (op[0]) wr(op[1], a, d);
            else begin
                rd(op[1], a, r);
                check($sformatf("R%0d table[%0d]", rq, i), 64'(r), 64'(e));
            end
        end

        // R3 unit step and R11 port mirror
        wr(1'b0, 12'h008, 32'h0); wr(1'b0, 12'h00C, 32'h0);
        run_for(32'h1, 4);
        check("R3 five ticks", count_out, 64'd5);
        rd(1'b0, 12'h008, r); check("R11 port vs read", count_out, 64'(r));
        idle(3);
        check("R2 stopped hold", count_out, 64'd5);

        // R3 carry into high half
        wr(1'b0, 12'h008, 32'hFFFF_FFFE);
        run_for(32'h1, 2);
        check("R3 half carry", count_out, 64'h1_0000_0001);
        rd(1'b1, 12'h004, r); check("R8 status high", 64'(r), 64'h1);

        // R4 scaled: 4 x 0.5 = 2, then 3 x 1.5 -> 6.5, then + 1.5 -> 8
        wr(1'b0, 12'h008, 32'h0); wr(1'b0, 12'h00C, 32'h0);
        wr(1'b0, 12'h010, 32'h0080_0000);
        run_for(32'h5, 3);
        check("R4 half scale", count_out, 64'd2);
        wr(1'b0, 12'h010, 32'h0180_0000);
        run_for(32'h5, 2);
        check("R4 1.5 scale", count_out, 64'd6);
        run_for(32'h5, 0);
        check("R4 fraction kept", count_out, 64'd8);

        // R6 count write clears fraction: 8 + 1.5 = 9.5, rewrite 9, + 1.5 = 10.5
        run_for(32'h5, 0);
        check("R6 pre", count_out, 64'd9);
        wr(1'b0, 12'h008, 32'd9);
        run_for(32'h5, 0);
        check("R6 fraction cleared", count_out, 64'd10);

        // R6 write wins over the tick while running
        wr(1'b0, 12'h000, 32'h1);
        idle(1);
        wr(1'b0, 12'h008, 32'h100);
        wr(1'b0, 12'h000, 32'h0);
        check("R6 write while running", count_out, 64'h101);

        // R4 largest scale: 2 x 0xFFFFFFFF -> count 0x1FF
        wr(1'b0, 12'h008, 32'h0);
        wr(1'b0, 12'h010, 32'hFFFF_FFFF);
        run_for(32'h5, 1);
        check("R4 max scale", count_out, 64'h1FF);

        // R1 reset in mid-operation
        wr(1'b0, 12'h000, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset count", count_out, 64'h0);
        rd(1'b0, 12'h010, r); check("R1 re-reset scale", 64'(r), 64'h0100_0000);
        rd(1'b0, 12'h000, r); check("R1 re-reset cfg", 64'(r), 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule